// File: doc/BRIEF.md
# Dual-Line Continuous Read Front End

This block is the serial-interface front end of a flash memory that answers two read commands: one that takes its address on a single line and returns data on two lines, and one that moves the address, a mode byte and the data over both lines. The host drives chip select, the serial clock and two data lines. The block drives the data lines back through separate output and output-enable pins. It fetches each byte from a simple synchronous memory-read port and streams it out two bits per serial clock. The address advances by one for each byte and wraps at the top of the 4 MiB space.

A mode byte ends the address of the two-line command. If its upper nibble is Ah, the block enters a continuous-read state. In that state the next transaction carries no opcode and begins directly with the two-line address. Any other mode byte returns the block to normal command decoding. A dedicated escape sequence forces the block out of the continuous state. Raising chip select abandons any transaction that is part done.

The serial clock, chip select and data inputs are sampled in the system clock domain. They must already be synchronous to `clk`. The serial clock must stay high for at least 6 `clk` cycles, and low for at least 6 `clk` cycles.

Top module: `dual_read_engine`

## Requirements
- R1: After reset, and within one clock of `cs_n` being high, `io_oe` is 2'b00 and the block drives neither line.
- R2: Input bits are sampled on rising edges of `sck`, and output pairs change only after falling edges. Both an idle-low clock (mode 0) and an idle-high clock (mode 3) at chip-select fall are accepted.
- R3: Opcode 3Bh, sent MSB first on `io_in[0]`, selects the single-line-address read. It takes 24 address bits, MSB first, on `io_in[0]`. Eight dummy clocks follow, and then the two-line data.
- R4: Opcode BBh selects the two-line read. The 24-bit address arrives MSB first in 12 clocks, with `io_in[1]` carrying the more significant bit of each pair. A mode byte follows in 4 clocks with the same bit order.
- R5: `io_oe` stays 2'b00 during the opcode, address, mode and dummy clocks. The two-line read uses 4 dummy clocks after the mode byte.
- R6: Each data byte takes 4 clocks, most significant pair first, with `io_out[1]` carrying the higher bit of each pair. The first byte read is the one at the low 22 bits of the received address.
- R7: The byte address increments once per byte while chip select stays low, and it wraps from 3FFFFFh to 000000h.
- R8: A mode byte whose upper nibble is Ah makes the next transaction skip the opcode and begin with the two-line address.
- R9: A mode byte with any other upper nibble makes the next transaction start with an opcode.
- R10: While continuous mode is active, the first bits of a transaction are taken as address, even if they match an opcode.
- R11: The escape sequence is an address top byte of FFh, meaning both lines held high for the first 4 clocks of a continuous transaction. It leaves continuous mode and returns no data. Opcode FFh in normal mode is accepted and has no effect.
- R12: Raising `cs_n` aborts the transaction and releases both lines. The continuous-mode state set by the last complete mode byte is kept.
- R13: Any opcode other than 3Bh, BBh and FFh is ignored for the rest of the transaction, and `io_oe` stays 2'b00.
- R14: Each fetch is a one-cycle `mem_req` pulse with `mem_addr`, and `mem_rdata` is valid on the following cycle. Reading N whole bytes issues N+1 fetches, because the next byte is always fetched ahead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| io_in | input | 2 | Data line inputs; bit 0 is the single-line input |
| io_out | output | 2 | Data line output values |
| io_oe | output | 2 | Data line output enables |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | 22 | Memory byte address |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_req` |

## Verification
The bench enters and leaves continuous mode in both directions. It sends a continuous transaction whose first byte equals the single-line opcode; a design that still decoded opcodes there would return data from the wrong address, or none. It also runs the escape sequence and then a normal read. A design that stayed in continuous mode would misread that opcode as address bits, and the expected bytes would go missing. The bench further reads across the 3FFFFFh wrap, where a design that wrapped at 24 bits would return the wrong bytes, and cuts a read off mid-byte. After the cut it expects the lines to be released and the continuous state to carry over into the next transaction.

// File: rtl/dread_pkg.sv
package dread_pkg;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_DATA,
        PH_SKIP
    } phase_t;

    localparam logic [7:0] OPC_DOUT = 8'h3B;
    localparam logic [7:0] OPC_DIO  = 8'hBB;
    localparam logic [7:0] OPC_MRST = 8'hFF;
    localparam logic [3:0] CONT_KEY = 4'hA;

    // collect one clock worth of input bits: two when wide, else io_in[0]
    function automatic logic [23:0] shift_in(logic [23:0] sh, logic wide, logic [1:0] d);
        return wide ? {sh[21:0], d[1], d[0]} : {sh[22:0], d[0]};
    endfunction

    // pair p of a byte, most significant pair first
    function automatic logic [1:0] pick_pair(logic [7:0] b, logic [1:0] p);
        case (p)
            2'd0:    return b[7:6];
            2'd1:    return b[5:4];
            2'd2:    return b[3:2];
            default: return b[1:0];
        endcase
    endfunction

endpackage

// File: rtl/dread_edge.sv
module dread_edge (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    output logic rise,
    output logic fall
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck;
    end

    assign rise = sck & ~sck_q;
    assign fall = ~sck & sck_q;
endmodule

// File: rtl/dread_ser.sv
module dread_ser #(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              fall,
    output logic [1:0]        io_out,
    output logic [1:0]        io_oe,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);
    import dread_pkg::*;

    logic [7:0] rbuf;
    logic [1:0] pair;
    logic       req_q;
    logic       active;

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            io_out  <= 2'b00;
            io_oe   <= 2'b00;
            pair    <= 2'd0;
            mem_req <= 1'b0;
            req_q   <= 1'b0;
            active  <= 1'b0;
        end else begin
            mem_req <= 1'b0;
            req_q   <= mem_req;
            if (start) begin
                active  <= 1'b1;
                pair    <= 2'd0;
                mem_req <= 1'b1;
            end else if (active && fall) begin
                io_out <= pick_pair(rbuf, pair);
                io_oe  <= 2'b11;
                pair   <= pair + 2'd1;
                if (pair == 2'd3) mem_req <= 1'b1;   // fetch the next byte ahead
            end
        end
    end

    // address and buffer survive chip select so only reset clears them
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            rbuf     <= 8'h00;
        end else begin
            if (req_q) rbuf <= mem_rdata;
            if (!cs_n && start)
                mem_addr <= start_addr;
            else if (!cs_n && active && fall && pair == 2'd3)
                mem_addr <= mem_addr + 1'b1;         // natural wrap at ADDR_W bits
        end
    end

    // R14: a fetch strobe lasts exactly one cycle
    assert_req_pulse_R14: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R1: lines released the cycle after chip select is seen high
    assert_release_R1: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (io_oe == 2'b00));

    // R6: both lines turn around together
    assert_oe_pair_R6: assert property (@(posedge clk) disable iff (rst)
        (io_oe == 2'b00) || (io_oe == 2'b11));
endmodule

// File: rtl/dual_read_engine.sv
module dual_read_engine #(
    parameter int ADDR_W     = 22,
    parameter int DUMMY_DIO  = 4,
    parameter int DUMMY_DOUT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic [1:0]        io_in,
    output logic [1:0]        io_out,
    output logic [1:0]        io_oe,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);
    import dread_pkg::*;

    localparam int CNT_W = 5;
    localparam logic [CNT_W-1:0] LAST_OPC    = CNT_W'(7);
    localparam logic [CNT_W-1:0] LAST_ADDR_W = CNT_W'(11);
    localparam logic [CNT_W-1:0] LAST_ADDR_N = CNT_W'(23);
    localparam logic [CNT_W-1:0] LAST_MODE   = CNT_W'(3);
    localparam logic [CNT_W-1:0] LAST_DMY_W  = CNT_W'(DUMMY_DIO - 1);
    localparam logic [CNT_W-1:0] LAST_DMY_N  = CNT_W'(DUMMY_DOUT - 1);

    logic rise, fall;
    phase_t ph;
    logic wide;
    logic cont;
    logic [CNT_W-1:0] cnt;
    logic [23:0] sh, sh_nx;
    logic start;
    logic [ADDR_W-1:0] start_addr;

    dread_edge u_edge (
        .clk (clk),
        .rst (rst),
        .sck (sck),
        .rise(rise),
        .fall(fall)
    );

    assign sh_nx = shift_in(sh, wide, io_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_CMD;
            wide       <= 1'b0;
            cont       <= 1'b0;
            cnt        <= '0;
            sh         <= '0;
            start      <= 1'b0;
            start_addr <= '0;
        end else begin
            start <= 1'b0;
            if (cs_n) begin
                ph   <= cont ? PH_ADDR : PH_CMD;
                wide <= cont;
                cnt  <= '0;
            end else if (rise) begin
                sh  <= sh_nx;
                cnt <= cnt + 1'b1;
                case (ph)
                    PH_CMD: if (cnt == LAST_OPC) begin
                        cnt <= '0;
                        case (sh_nx[7:0])
                            OPC_DIO:  begin ph <= PH_ADDR; wide <= 1'b1; end
                            OPC_DOUT: begin ph <= PH_ADDR; wide <= 1'b0; end
                            OPC_MRST: begin ph <= PH_SKIP; cont <= 1'b0; end
                            default:  ph <= PH_SKIP;
                        endcase
                    end
                    PH_ADDR: begin
                        if (cont && cnt == LAST_MODE && sh_nx[7:0] == OPC_MRST) begin
                            cont <= 1'b0;                    // escape from continuous mode
                            ph   <= PH_SKIP;
                        end else if (cnt == (wide ? LAST_ADDR_W : LAST_ADDR_N)) begin
                            cnt        <= '0;
                            start_addr <= sh_nx[ADDR_W-1:0];
                            ph         <= wide ? PH_MODE : PH_DUMMY;
                        end
                    end
                    PH_MODE: if (cnt == LAST_MODE) begin
                        cnt  <= '0;
                        cont <= (sh_nx[7:4] == CONT_KEY);
                        ph   <= PH_DUMMY;
                    end
                    PH_DUMMY: if (cnt == (wide ? LAST_DMY_W : LAST_DMY_N)) begin
                        cnt   <= '0;
                        ph    <= PH_DATA;
                        start <= 1'b1;
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    dread_ser #(.ADDR_W(ADDR_W)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .start     (start),
        .start_addr(start_addr),
        .fall      (fall),
        .io_out    (io_out),
        .io_oe     (io_oe),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata)
    );

    // R5: lines are driven only in the data phase
    assert_oe_data_only_R5: assert property (@(posedge clk) disable iff (rst)
        (io_oe != 2'b00) |-> (ph == PH_DATA));

    // R8: continuous state moves only on a sampled clock rise
    assert_cont_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(cont) |-> $past(rise));

    // R13: a skipped transaction never fetches
    assert_skip_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SKIP) |-> !mem_req);
endmodule

// File: tb/test_dual_read_engine.sv
module test_dual_read_engine;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic [1:0] io_in = 2'b00;
    logic [1:0] io_out, io_oe;
    logic mem_req;
    logic [21:0] mem_addr;
    logic [7:0] mem_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int req_cnt = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string cur_tag = "";
    logic [7:0] mon_byte = 8'h00;
    int mon_n = 0;

    always #10 clk = ~clk;

    dual_read_engine i_dual_read_engine (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] memf(logic [21:0] a);
        return a[7:0] ^ a[15:8] ^ {2'b10, a[21:16]};
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= memf(mem_addr);
            req_cnt <= req_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: assemble pairs seen at sampling edges, compare with scoreboard
    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            mon_n = 0;
        end else if (io_oe == 2'b11) begin
            mon_byte = {mon_byte[5:0], io_out[1], io_out[0]};
            mon_n++;
            if (mon_n == 4) begin
                mon_n = 0;
                if (exp_q.size() == 0) begin
                    chk(0, {cur_tag, " unexpected byte"}, mon_byte, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(mon_byte == e, cur_tag, mon_byte, e);
                end
            end
        end
    end

    task automatic clk_bit(input logic [1:0] d);
        sck <= 1'b0; io_in <= d;
        repeat (H) @(negedge clk);
        sck <= 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic open_txn(input bit mode3);
        sck <= mode3;
        repeat (H) @(negedge clk);
        cs_n <= 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic close_txn(input string tag);
        sck <= 1'b0;
        repeat (H) @(negedge clk);
        cs_n <= 1'b1;
        repeat (2) @(negedge clk);
        chk(io_oe == 2'b00, {tag, " R1 lines released"}, io_oe, 0);
        chk(exp_q.size() == 0, {tag, " all bytes returned"}, exp_q.size(), 0);
        exp_q.delete();
        repeat (H) @(negedge clk);
    endtask

    task automatic single_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) clk_bit({1'b0, b[i]});
    endtask

    task automatic dual_byte(input logic [7:0] b);
        for (int i = 3; i >= 0; i--) clk_bit({b[2*i+1], b[2*i]});
    endtask

    task automatic dummies(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            clk_bit(2'b00);
            chk(io_oe == 2'b00, {tag, " R5 no drive in dummy"}, io_oe, 0);
        end
    endtask

    task automatic read_bytes(input logic [21:0] a, input int n, input string tag);
        cur_tag = tag;
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(memf(a + 22'(k)));
            for (int p = 0; p < 4; p++) clk_bit(2'b00);
        end
    endtask

    task automatic dout_read(input logic [23:0] a, input int n, input string tag);
        open_txn(0);
        single_byte(8'h3B);
        single_byte(a[23:16]); single_byte(a[15:8]); single_byte(a[7:0]);
        chk(io_oe == 2'b00, {tag, " R5 no drive in address"}, io_oe, 0);
        dummies(8, tag);
        read_bytes(a[21:0], n, tag);
        close_txn(tag);
    endtask

    task automatic dio_body(input logic [23:0] a, input logic [7:0] m, input int n,
                            input string tag);
        dual_byte(a[23:16]); dual_byte(a[15:8]); dual_byte(a[7:0]);
        dual_byte(m);
        chk(io_oe == 2'b00, {tag, " R5 no drive in mode"}, io_oe, 0);
        dummies(4, tag);
        read_bytes(a[21:0], n, tag);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst <= 1'b0;
        @(negedge clk);
        chk(io_oe == 2'b00, "R1 reset oe", io_oe, 0);
        chk(mem_req == 1'b0, "R1 reset mem_req", mem_req, 0);

        // single-line address read, fetch count
        req_cnt = 0;
        dout_read(24'h000120, 3, "R3 R6 dual output");
        chk(req_cnt == 4, "R14 fetch count", req_cnt, 4);

        // unknown opcode
        open_txn(0);
        single_byte(8'h03);
        for (int i = 0; i < 24; i++) begin
            clk_bit(2'b11);
            chk(io_oe == 2'b00, "R13 unknown opcode silent", io_oe, 0);
        end
        close_txn("R13");

        // two-line read with idle-high clock, enters continuous mode
        open_txn(1);
        single_byte(8'hBB);
        dio_body(24'h123456, 8'hA5, 2, "R2 R4 dual io mode3");
        close_txn("R4");

        // continuous: no opcode
        open_txn(0);
        dio_body(24'h001000, 8'hA0, 2, "R8 continuous read");
        close_txn("R8");

        // continuous: opcode value taken as address, then exit with mode 00h
        open_txn(0);
        dio_body(24'h3B0010, 8'h00, 2, "R10 opcode as address");
        close_txn("R10");

        // opcode required again
        open_txn(0);
        single_byte(8'hBB);
        dio_body(24'h000200, 8'hAF, 1, "R9 opcode after exit");
        close_txn("R9");

        // escape from continuous mode
        open_txn(0);
        for (int i = 0; i < 8; i++) begin
            clk_bit(2'b11);
            chk(io_oe == 2'b00, "R11 escape silent", io_oe, 0);
        end
        close_txn("R11");
        dout_read(24'h000300, 1, "R11 normal after escape");

        // opcode FFh in normal mode
        open_txn(0);
        single_byte(8'hFF);
        for (int i = 0; i < 8; i++) clk_bit(2'b00);
        chk(io_oe == 2'b00, "R11 FFh opcode no effect", io_oe, 0);
        close_txn("R11");
        dout_read(24'h000310, 1, "R11 normal after FFh");

        // wrap at top of space
        dout_read(24'h3FFFFE, 4, "R7 wrap");

        // abort mid-byte, continuous state kept
        open_txn(0);
        single_byte(8'hBB);
        dio_body(24'h000400, 8'hA1, 1, "R12 before abort");
        clk_bit(2'b00); clk_bit(2'b00);
        cs_n <= 1'b1;
        repeat (2) @(negedge clk);
        chk(io_oe == 2'b00, "R12 abort releases lines", io_oe, 0);
        chk(exp_q.size() == 0, "R12 whole bytes only", exp_q.size(), 0);
        sck <= 1'b0;
        repeat (2 * H) @(negedge clk);
        open_txn(0);
        dio_body(24'h000500, 8'h00, 1, "R12 continuous kept");
        close_txn("R12");

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule